// File: doc/BRIEF.md
# Return Stack Buffer

This block predicts the targets of near return instructions. Every near call with a non-zero displacement pushes the address of the instruction that follows it onto a circular stack. The front end reads the entry on top of the stack as the predicted target of the next near return, and a near return pops it. A call whose target is simply the next instruction (zero displacement) does not push. Far calls, far returns and interrupt returns neither read nor change the stack.

When the stack holds no live entry, the block raises an empty flag. A separate target predictor then supplies the return target. A flush discards every entry in one cycle.

Both event inputs are valid-qualified streams that the block always accepts. It applies no back-pressure, so there is no ready signal and every event is taken on the edge where its valid is high. The prediction outputs come straight from registered state and are never stalled.

Top module: `return_stack_buf`

## Requirements
- R1: A near call (call_valid=1, call_zero_disp=0, call_far=0) pushes call_ret_addr. From the next cycle pred_addr equals that address and pred_valid=1.
- R2: A call with call_zero_disp=1 leaves the stack unchanged. pred_addr, pred_valid and rsb_empty hold their values.
- R3: A call with call_far=1 and a return with ret_far=1 (a far return or an interrupt return) leave the stack unchanged. pred_addr, pred_valid and rsb_empty hold their values.
- R4: The depth is 32. After at least 32 pushes, 32 near returns (ret_valid=1, ret_far=0) see the 32 most recently pushed addresses in reverse order of pushing. After the last of them the stack is empty.
- R5: rsb_empty=1 and pred_valid=0 exactly when no live entry remains. In that state pred_addr reads zero.
- R6: A push onto a full stack overwrites the oldest entry, and the occupancy stays at 32.
- R7: A near return on an empty stack changes nothing. The stack stays empty, and a later push followed by a return behaves as if the empty pop never happened.
- R8: A flush empties the stack on the next edge. It takes priority over a push or a pop in the same cycle.
- R9: A push and a near return in the same cycle replace the top entry with the new address and leave the entries below unchanged. On an empty stack the same pair leaves exactly one entry.
- R10: After reset the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_valid | input | 1 | A call event is present |
| call_ret_addr | input | ADDR_W | Address of the instruction after the call |
| call_zero_disp | input | 1 | The call targets the next sequential instruction |
| call_far | input | 1 | The call is a far call |
| ret_valid | input | 1 | A return event is present |
| ret_far | input | 1 | The return is a far return or an interrupt return |
| flush | input | 1 | Discard all entries |
| pred_addr | output | ADDR_W | Predicted near-return target |
| pred_valid | output | 1 | pred_addr holds a live entry |
| rsb_empty | output | 1 | No live entry; an alternate predictor should be used |

## Verification
Every event changes state on the edge where it is presented. Because the outputs are driven from that state with no further register, each result is due one cycle after its stimulus. The bench's driver applies each event half a cycle before an edge. Just after that edge it queues the expected prediction, worked out from a reference stack built only from the requirements. The monitor compares that entry at the following falling edge, so each check lands in the first cycle after its event. The sequences cover pushes past full, a run of returns back to empty, returns on an empty stack, same-cycle push and return, a flush that collides with a push, and the excluded call and return kinds.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [1:0] {
    RSB_IDLE = 2'd0,
    RSB_PUSH = 2'd1,
    RSB_POP  = 2'd2,
    RSB_SWAP = 2'd3
  } rsb_op_e;

  // Reduce raw event pins to one stack operation.
  function automatic rsb_op_e rsb_decode(input logic cv, input logic zd, input logic cf,
                                         input logic rv, input logic rf);
    logic push, pop;
    push = cv & ~zd & ~cf;
    pop  = rv & ~rf;
    if (push && pop)  return RSB_SWAP;
    else if (push)    return RSB_PUSH;
    else if (pop)     return RSB_POP;
    else              return RSB_IDLE;
  endfunction
endpackage

// File: rtl/rsb_ptr_ctrl.sv
module rsb_ptr_ctrl
  import rsb_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rsb_op_e          op,
  input  logic             flush,
  output logic [PTR_W-1:0] tos_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_idx
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] IDX_LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] nxt_idx, prv_idx, tos_d;
  logic [CNT_W-1:0] cnt_d;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
      assign nxt_idx = tos_q + 1'b1;
      assign prv_idx = tos_q - 1'b1;
    end else begin : g_cmp_wrap
      assign nxt_idx = (tos_q == IDX_LAST) ? '0 : tos_q + 1'b1;
      assign prv_idx = (tos_q == '0) ? IDX_LAST : tos_q - 1'b1;
    end
  endgenerate

  always_comb begin
    tos_d  = tos_q;
    cnt_d  = cnt_q;
    wr_en  = 1'b0;
    wr_idx = tos_q;
    if (flush) begin
      cnt_d = '0;
    end else begin
      unique case (op)
        RSB_PUSH: begin
          wr_en  = 1'b1;
          wr_idx = nxt_idx;
          tos_d  = nxt_idx;
          cnt_d  = (cnt_q == CNT_FULL) ? cnt_q : cnt_q + 1'b1;
        end
        RSB_POP: begin
          if (cnt_q != '0) begin
            tos_d = prv_idx;
            cnt_d = cnt_q - 1'b1;
          end
        end
        RSB_SWAP: begin
          wr_en = 1'b1;
          if (cnt_q == '0) cnt_d = CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q <= '0;
      cnt_q <= '0;
    end else begin
      tos_q <= tos_d;
      cnt_q <= cnt_d;
    end
  end

  // R4 / R6: occupancy never exceeds the depth
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R1: a push below full grows occupancy by one
  assert_push_grows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RSB_PUSH && !flush && cnt_q != CNT_FULL) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R6: a push on a full stack keeps it full
  assert_full_saturates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RSB_PUSH && !flush && cnt_q == CNT_FULL) |=> cnt_q == CNT_FULL);

  // R7: a pop on an empty stack moves nothing
  assert_empty_pop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RSB_POP && !flush && cnt_q == '0) |=> (cnt_q == '0 && $stable(tos_q)));

  // R8: flush empties on the next edge
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> cnt_q == '0);

  // R9: push and pop together keep the pointer where it was
  assert_swap_keeps_tos_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RSB_SWAP && !flush) |=> $stable(tos_q));
endmodule

// File: rtl/rsb_store.sv
module rsb_store #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] ent [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && wr_idx == PTR_W'(i)) ent[i] <= wr_data;
    end
  end

  assign rd_data = ent[rd_idx];

  // R1 / R9: a written entry holds the written address afterwards
  assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/return_stack_buf.sv
module return_stack_buf
  import rsb_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_valid,
  input  logic [ADDR_W-1:0] call_ret_addr,
  input  logic              call_zero_disp,
  input  logic              call_far,
  input  logic              ret_valid,
  input  logic              ret_far,
  input  logic              flush,
  output logic [ADDR_W-1:0] pred_addr,
  output logic              pred_valid,
  output logic              rsb_empty
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  rsb_op_e           op;
  logic [PTR_W-1:0]  tos, wr_idx;
  logic [CNT_W-1:0]  cnt;
  logic              wr_en;
  logic [ADDR_W-1:0] top_data;

  assign op = rsb_decode(call_valid, call_zero_disp, call_far, ret_valid, ret_far);

  rsb_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .flush  (flush),
    .tos_q  (tos),
    .cnt_q  (cnt),
    .wr_en  (wr_en),
    .wr_idx (wr_idx)
  );

  rsb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (call_ret_addr),
    .rd_idx  (tos),
    .rd_data (top_data)
  );

  assign rsb_empty  = (cnt == '0);
  assign pred_valid = ~rsb_empty;
  assign pred_addr  = rsb_empty ? '0 : top_data;

  // R2 / R3: excluded call kinds with no near return leave the outputs untouched
  assert_excluded_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (call_valid && (call_zero_disp || call_far) && !(ret_valid && !ret_far) && !flush)
    |=> ($stable(pred_addr) && $stable(rsb_empty)));

  // R3: a far or interrupt return with no push leaves the outputs untouched
  assert_far_ret_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_far && !(call_valid && !call_zero_disp && !call_far) && !flush)
    |=> ($stable(pred_addr) && $stable(rsb_empty)));

  // R1: a near call makes its address the prediction on the next cycle
  assert_push_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == RSB_PUSH && !flush) |=> (pred_valid && pred_addr == $past(call_ret_addr)));
endmodule

// File: tb/return_stack_buf_tb_top.sv
module return_stack_buf_tb_top;
  localparam int  AW      = 32;
  localparam int  DEPTH   = 32;
  localparam time CLK_PER = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_valid = 1'b0, call_zero_disp = 1'b0, call_far = 1'b0;
  logic [AW-1:0] call_ret_addr = '0;
  logic          ret_valid = 1'b0, ret_far = 1'b0, flush = 1'b0;
  logic [AW-1:0] pred_addr;
  logic          pred_valid, rsb_empty;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [AW-1:0] addr;
    logic          valid;
    string         tag;
  } exp_t;

  exp_t          exp_q[$];
  logic [AW-1:0] model[$];

  always #(CLK_PER/2) clk = ~clk;

  return_stack_buf #(.DEPTH(DEPTH), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .call_valid(call_valid), .call_ret_addr(call_ret_addr),
    .call_zero_disp(call_zero_disp), .call_far(call_far),
    .ret_valid(ret_valid), .ret_far(ret_far), .flush(flush),
    .pred_addr(pred_addr), .pred_valid(pred_valid), .rsb_empty(rsb_empty)
  );

  task automatic compare(input exp_t e);
    checks++;
    if (pred_addr !== e.addr || pred_valid !== e.valid || rsb_empty !== !e.valid) begin
      errors++;
      $display("FAIL %s: addr=%h valid=%b empty=%b, expected addr=%h valid=%b empty=%b",
               e.tag, pred_addr, pred_valid, rsb_empty, e.addr, e.valid, !e.valid);
    end
  endtask

  // Driver: one event per cycle, expected outcome queued after the edge.
  task automatic step(input bit cv, input logic [AW-1:0] a, input bit zd, input bit cf,
                      input bit rv, input bit rf, input bit fl, input string tag);
    bit   push, pop;
    exp_t e;
    @(negedge clk);
    call_valid = cv; call_ret_addr = a; call_zero_disp = zd; call_far = cf;
    ret_valid = rv; ret_far = rf; flush = fl;
    @(posedge clk);
    push = cv && !zd && !cf;
    pop  = rv && !rf;
    if (fl) model.delete();
    else if (push && pop) begin
      if (model.size() == 0) model.push_back(a);
      else model[model.size()-1] = a;
    end else if (push) begin
      model.push_back(a);
      if (model.size() > DEPTH) void'(model.pop_front());
    end else if (pop) begin
      if (model.size() > 0) void'(model.pop_back());
    end
    e.valid = (model.size() > 0);
    e.addr  = e.valid ? model[model.size()-1] : '0;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  task automatic call_n(input logic [AW-1:0] a, input string tag);
    step(1, a, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic ret_n(input string tag);
    step(0, '0, 0, 0, 1, 0, 0, tag);
  endtask

  // Monitor: compare one queued expectation per falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    r.addr = '0; r.valid = 1'b0; r.tag = "R10 reset";
    compare(r);

    // R1 basic pushes and returns
    call_n(32'h0000_1004, "R1 push a");
    call_n(32'h0000_2008, "R1 push b");
    ret_n("R1 pop b");
    // R2 zero-displacement call must not push
    step(1, 32'hDEAD_0001, 1, 0, 0, 0, 0, "R2 zero disp");
    // R3 far call, far return, interrupt return
    step(1, 32'hDEAD_0002, 0, 1, 0, 0, 0, "R3 far call");
    step(0, '0, 0, 0, 1, 1, 0, "R3 far return");
    step(1, 32'hDEAD_0003, 1, 1, 1, 1, 0, "R3 mixed excluded");
    ret_n("R5 pop to empty");
    // R7 returns on empty
    ret_n("R7 empty pop 1");
    ret_n("R7 empty pop 2");
    call_n(32'h0000_3000, "R7 push after empty pop");
    ret_n("R7 pop after push");
    // R9 push and return together
    step(1, 32'h0000_4000, 0, 0, 1, 0, 0, "R9 swap on empty");
    call_n(32'h0000_5000, "R9 push");
    step(1, 32'h0000_6000, 0, 0, 1, 0, 0, "R9 swap on top");
    ret_n("R9 below kept");
    ret_n("R9 empty after");
    // R6 / R4 overfill then drain
    for (int i = 0; i < DEPTH + 8; i++) call_n(32'hA000_0000 + i, "R6 fill past full");
    for (int i = 0; i < DEPTH; i++) ret_n("R4 drain order");
    ret_n("R5 drained empty");
    // R8 flush, including a colliding push
    call_n(32'h0000_7000, "R8 setup");
    call_n(32'h0000_7100, "R8 setup");
    step(1, 32'h0000_7200, 0, 0, 0, 0, 1, "R8 flush with push");
    ret_n("R8 stays empty");
    call_n(32'h0000_8000, "R8 usable after flush");
    step(0, '0, 0, 0, 1, 0, 1, "R8 flush with pop");
    step(0, '0, 0, 0, 0, 0, 0, "R5 idle");

    @(negedge clk);
    call_valid = 0; ret_valid = 0; flush = 0;
    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule